// File: doc/BRIEF.md
# Two-Level Segmented Address Translation Walker

The walker turns a virtual address made of a segment number and a word index into a physical word address. The descriptor table that holds one descriptor per segment is itself split into pages. A translation therefore makes two page-table lookups. The first finds the page of the descriptor table that holds the segment's descriptor. The second finds the data page named by the index. Each table word comes through a single request/acknowledge memory port. A small fully associative cache keeps recent table words so that a repeated translation needs no memory reads. Each translation ends with either a physical address or a three-bit fault code.

The control is one state machine with six states:
- `ST_IDLE` accepts `start`. It raises the segment-bound fault at once, or moves to `ST_DIR_PTW`.
- `ST_DIR_PTW` fetches the descriptor-table page-table word (PTW). On a cache miss it goes to `ST_DIR_MARK`, which writes that word back with its used bit set. On a cache hit it goes straight to `ST_DESC`.
- `ST_DESC` fetches the descriptor and runs the segment checks. It then moves to `ST_DATA_PTW`.
- `ST_DATA_PTW` fetches the data PTW. On a cache hit it finishes. On a miss it goes to `ST_DATA_MARK` for the used-bit write and then finishes.
- Every fault returns to `ST_IDLE`. So does every finish.

All table words share one layout. Bits `[PA_W-1:0]` hold an address: a frame base in a PTW, or a page-table base in a descriptor. The next `IDX_W` bits hold the segment length. The next 4 bits hold the rights mask. Bit `WD-2` is the used flag and bit `WD-1` is the absent flag, where `WD = PA_W+IDX_W+6`.

Top module: `segpage_walker`

## Requirements
- R1: If `seg` is greater than `dbr_len` when `start` is accepted, the next cycle pulses `fault` with code 1. No memory request is made for that translation. A segment equal to `dbr_len` is allowed.
- R2: The descriptor-table PTW is read at `dbr_base + seg[SEG_W-1:OFF_W]`. If its absent flag (bit WD-1) is set, the result is fault code 2.
- R3: The descriptor is read at the frame base from that PTW plus `seg[OFF_W-1:0]`. If its absent flag is set, the result is fault code 3.
- R4: If the absent check passes and `idx` is greater than the descriptor's length field, the result is fault code 4. An index equal to the length is allowed.
- R5: If the length check passes and the rights-mask bit selected by `op` is clear, the result is fault code 5. The `op` encoding is 0 read, 1 write, 2 execute, 3 append, and it selects mask bit 0, 1, 2 or 3.
- R6: The data PTW is read at the descriptor's page-table base plus `idx[IDX_W-1:OFF_W]`. If its absent flag is set, the result is fault code 6. Otherwise `done` pulses with `paddr` equal to the frame base plus `idx[OFF_W-1:0]`.
- R7: Each PTW fetched from memory without its absent flag is written back to the same address with the used bit (bit WD-2) set, before the walk continues.
- R8: A translation whose three table words are all cached issues no memory request at all. All bound, flag and rights checks still apply to the cached words.
- R9: A `flush` pulse empties the cache, so the next translation fetches its table words from memory again.
- R10: Each accepted `start` yields exactly one one-cycle pulse of `done` or `fault`, never both. `ready` is low from acceptance until that pulse. `mem_req` stays high with a stable address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Empty the table-word cache |
| start | input | 1 | Begin a translation (taken when `ready`) |
| op | input | 2 | Requested operation: 0 read, 1 write, 2 execute, 3 append |
| seg | input | SEG_W | Segment number |
| idx | input | IDX_W | Word index in the segment |
| dbr_base | input | PA_W | Base address of the descriptor-table page table |
| dbr_len | input | SEG_W | Highest legal segment number |
| ready | output | 1 | Walker idle, may accept `start` |
| done | output | 1 | Translation succeeded (one-cycle pulse) |
| fault | output | 1 | Translation faulted (one-cycle pulse) |
| fault_code | output | 3 | Fault reason, valid with `fault` |
| paddr | output | PA_W | Physical word address, valid with `done` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PA_W | Memory word address |
| mem_wdata | output | WD | Write data |
| mem_ack | input | 1 | Request completed (one-cycle pulse) |
| mem_rdata | input | WD | Read data, valid with `mem_ack` |

## Verification
The bench builds the walker with 4-bit segment numbers and indices, 4-word pages and a 10-bit physical address. Every combination of segment, index and operation, 1024 translations in all, can then be compared against an arithmetic model of the tables. That sweep reaches each fault code, the equal-to-limit cases for both bounds, and the checks made on cached words. Separate directed runs count memory reads and writes to show the used-bit write-back, the absence of memory traffic on a fully cached walk, and the refetch after a flush.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_EXEC   = 2'd2,
        OP_APPEND = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_SEG_BOUND  = 3'd1,
        FLT_DIR_PAGE   = 3'd2,
        FLT_SEG_ABSENT = 3'd3,
        FLT_IDX_BOUND  = 3'd4,
        FLT_ACCESS     = 3'd5,
        FLT_DATA_PAGE  = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_PTW,
        ST_DIR_MARK,
        ST_DESC,
        ST_DATA_PTW,
        ST_DATA_MARK
    } state_e;

    localparam int RIGHTS_W = 4;

endpackage

// File: rtl/segpage_rights.sv
module segpage_rights #(
    parameter int IDX_W = 18
) (
    input  logic [1:0]       op,
    input  logic [3:0]       rights,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] seg_len,
    output logic             idx_over,
    output logic             deny
);
    assign idx_over = idx > seg_len;
    assign deny     = !rights[op];
endmodule

// File: rtl/segpage_tcache.sv
module segpage_tcache #(
    parameter int N  = 8,
    parameter int AW = 24,
    parameter int DW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    input  logic          ins_en,
    input  logic [AW-1:0] ins_addr,
    input  logic [DW-1:0] ins_data
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  vld;
    logic [N-1:0]  match;
    logic [AW-1:0] tag [N];
    logic [DW-1:0] dat [N];
    logic [PW-1:0] ptr;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == look_addr);
    end

    assign hit = |match;

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < N; i++) begin
            hit_data = hit_data | (dat[i] & {DW{match[i]}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (ins_en) begin
            vld[ptr] <= 1'b1;
            tag[ptr] <= ins_addr;
            dat[ptr] <= ins_data;
            ptr      <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

    p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

// File: rtl/segpage_walker.sv
module segpage_walker
    import segpage_pkg::*;
#(
    parameter int SEG_W   = 18,
    parameter int IDX_W   = 18,
    parameter int OFF_W   = 10,
    parameter int PA_W    = 24,
    parameter int CACHE_N = 8,
    localparam int WD     = PA_W + IDX_W + RIGHTS_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [SEG_W-1:0] seg,
    input  logic [IDX_W-1:0] idx,
    input  logic [PA_W-1:0]  dbr_base,
    input  logic [SEG_W-1:0] dbr_len,
    output logic             ready,
    output logic             done,
    output logic             fault,
    output logic [2:0]       fault_code,
    output logic [PA_W-1:0]  paddr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [WD-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [WD-1:0]    mem_rdata
);
    localparam int LEN_LO  = PA_W;
    localparam int ACC_LO  = PA_W + IDX_W;
    localparam int B_USED  = WD - 2;
    localparam int B_ABSNT = WD - 1;

    state_e             state, nxt;
    logic [SEG_W-1:0]   seg_q;
    logic [IDX_W-1:0]   idx_q;
    logic [1:0]         op_q;
    logic [PA_W-1:0]    base_q, frame_q, pt_q, pa_q;
    logic [WD-1:0]      mark_q;
    logic               done_q, fault_q;
    logic [2:0]         code_q;

    logic [PA_W-1:0]    look_addr;
    logic               c_hit, got, rd_state;
    logic [WD-1:0]      c_data, word;
    logic               idx_over, deny;
    logic               fin_ok, fin_flt, ins_en;
    logic [2:0]         flt_code;
    logic [WD-1:0]      ins_data;

    segpage_tcache #(.N(CACHE_N), .AW(PA_W), .DW(WD)) u_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .look_addr(look_addr), .hit(c_hit), .hit_data(c_data),
        .ins_en(ins_en), .ins_addr(look_addr), .ins_data(ins_data)
    );

    segpage_rights #(.IDX_W(IDX_W)) u_rights (
        .op(op_q), .rights(word[ACC_LO +: RIGHTS_W]), .idx(idx_q),
        .seg_len(word[LEN_LO +: IDX_W]), .idx_over(idx_over), .deny(deny)
    );

    // table-word address for the current step
    always_comb begin
        unique case (state)
            ST_DESC:                  look_addr = frame_q + PA_W'(seg_q[OFF_W-1:0]);
            ST_DATA_PTW, ST_DATA_MARK: look_addr = pt_q + PA_W'(idx_q[IDX_W-1:OFF_W]);
            default:                  look_addr = base_q + PA_W'(seg_q[SEG_W-1:OFF_W]);
        endcase
    end

    assign rd_state = (state == ST_DIR_PTW) || (state == ST_DESC) || (state == ST_DATA_PTW);
    assign word     = c_hit ? c_data : mem_rdata;
    assign got      = rd_state && (c_hit || mem_ack);

    // next state and walk decisions
    always_comb begin
        nxt      = state;
        fin_ok   = 1'b0;
        fin_flt  = 1'b0;
        flt_code = FLT_NONE;
        ins_en   = 1'b0;
        ins_data = word;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (seg > dbr_len) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_SEG_BOUND;
                    end else begin
                        nxt = ST_DIR_PTW;
                    end
                end
            end
            ST_DIR_PTW: begin
                if (got) begin
                    if (word[B_ABSNT]) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_DIR_PAGE;
                        nxt      = ST_IDLE;
                    end else if (c_hit) begin
                        nxt = ST_DESC;
                    end else begin
                        ins_en           = 1'b1;
                        ins_data[B_USED] = 1'b1;
                        nxt              = ST_DIR_MARK;
                    end
                end
            end
            ST_DIR_MARK: begin
                if (mem_ack) nxt = ST_DESC;
            end
            ST_DESC: begin
                if (got) begin
                    nxt = ST_IDLE;
                    if (word[B_ABSNT]) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_SEG_ABSENT;
                    end else if (idx_over) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_IDX_BOUND;
                    end else if (deny) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_ACCESS;
                    end else begin
                        ins_en = !c_hit;
                        nxt    = ST_DATA_PTW;
                    end
                end
            end
            ST_DATA_PTW: begin
                if (got) begin
                    if (word[B_ABSNT]) begin
                        fin_flt  = 1'b1;
                        flt_code = FLT_DATA_PAGE;
                        nxt      = ST_IDLE;
                    end else if (c_hit) begin
                        fin_ok = 1'b1;
                        nxt    = ST_IDLE;
                    end else begin
                        ins_en           = 1'b1;
                        ins_data[B_USED] = 1'b1;
                        nxt              = ST_DATA_MARK;
                    end
                end
            end
            ST_DATA_MARK: begin
                if (mem_ack) begin
                    fin_ok = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= FLT_NONE;
            seg_q   <= '0;
            idx_q   <= '0;
            op_q    <= '0;
            base_q  <= '0;
            frame_q <= '0;
            pt_q    <= '0;
            pa_q    <= '0;
            mark_q  <= '0;
        end else begin
            state   <= nxt;
            done_q  <= fin_ok;
            fault_q <= fin_flt;
            code_q  <= fin_flt ? flt_code : FLT_NONE;
            if (state == ST_IDLE && start) begin
                seg_q  <= seg;
                idx_q  <= idx;
                op_q   <= op;
                base_q <= dbr_base;
            end
            if (got) begin
                mark_q         <= word;
                mark_q[B_USED] <= 1'b1;
            end
            if (state == ST_DIR_PTW && got) frame_q <= word[PA_W-1:0];
            if (state == ST_DESC && got)    pt_q    <= word[PA_W-1:0];
            if (state == ST_DATA_PTW && got)
                pa_q <= word[PA_W-1:0] + PA_W'(idx_q[OFF_W-1:0]);
        end
    end

    // outputs
    always_comb begin
        ready      = (state == ST_IDLE);
        done       = done_q;
        fault      = fault_q;
        fault_code = code_q;
        paddr      = pa_q;
        mem_we     = (state == ST_DIR_MARK) || (state == ST_DATA_MARK);
        mem_req    = mem_we || (rd_state && !c_hit);
        mem_addr   = look_addr;
        mem_wdata  = mark_q;
    end

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (!ready || done || fault));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_bound_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && (seg > dbr_len)) |=> (fault && fault_code == 3'(FLT_SEG_BOUND) && !mem_req));

    p_mark_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[B_USED] && !mem_wdata[B_ABSNT]));

    p_code_with_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 3'(FLT_NONE)));

endmodule

// File: tb/segpage_walker_tb.sv
module segpage_walker_tb;
    localparam int SEG_W = 4;
    localparam int IDX_W = 4;
    localparam int OFF_W = 2;
    localparam int PA_W  = 10;
    localparam int WD    = PA_W + IDX_W + 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       op = '0;
    logic [SEG_W-1:0] seg = '0;
    logic [IDX_W-1:0] idx = '0;
    logic [PA_W-1:0]  dbr_base = '0;
    logic [SEG_W-1:0] dbr_len = '0;
    logic             ready, done, fault;
    logic [2:0]       fault_code;
    logic [PA_W-1:0]  paddr;
    logic             mem_req, mem_we;
    logic [PA_W-1:0]  mem_addr;
    logic [WD-1:0]    mem_wdata;
    logic             mem_ack = 1'b0;
    logic [WD-1:0]    mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int wait_cnt = 0;
    logic [WD-1:0] mem [0:1023];

    always #5 clk = ~clk;

    segpage_walker #(.SEG_W(SEG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .CACHE_N(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start(start), .op(op),
        .seg(seg), .idx(idx), .dbr_base(dbr_base), .dbr_len(dbr_len),
        .ready(ready), .done(done), .fault(fault), .fault_code(fault_code),
        .paddr(paddr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // table model
    function automatic logic [WD-1:0] mkw(bit absent, int acc, int len, int a);
        logic [WD-1:0] r;
        r = {absent, 1'b0, acc[3:0], len[3:0], a[9:0]};
        return r;
    endfunction
    function automatic int ds_frame(int sp); return 64 + sp * 16; endfunction
    function automatic int s_len(int s); return (s * 5 + 3) % 16; endfunction
    function automatic int s_acc(int s); return (s * 7 + 3) % 16; endfunction
    function automatic int s_pt(int s); return 256 + s * 4; endfunction
    function automatic bit dp_absent(int s, int ip); return ((s + ip) % 5) == 4; endfunction
    function automatic int dp_frame(int s, int ip); return 512 + (s * 4 + ip) * 4; endfunction

    function automatic logic [WD-1:0] init_word(int a);
        if (a < 4) return mkw(a == 2, 0, 0, ds_frame(a));
        if (a >= 64 && a < 128 && ((a - 64) % 16) < 4)
            return mkw(((a - 64) / 16) * 4 + (a - 64) % 16 == 7,
                       s_acc(((a - 64) / 16) * 4 + (a - 64) % 16),
                       s_len(((a - 64) / 16) * 4 + (a - 64) % 16),
                       s_pt(((a - 64) / 16) * 4 + (a - 64) % 16));
        if (a >= 256 && a < 320)
            return mkw(dp_absent((a - 256) / 4, a % 4), 0, 0, dp_frame((a - 256) / 4, a % 4));
        return '0;
    endfunction

    task automatic expect_of(input int s, input int i, input int o, input int dl,
                             output int code, output int pa);
        pa = 0;
        if (s > dl)                              code = 1;
        else if ((s / 4) == 2)                   code = 2;
        else if (s == 7)                         code = 3;
        else if (i > s_len(s))                   code = 4;
        else if (((s_acc(s) >> o) & 1) == 0)     code = 5;
        else if (dp_absent(s, i / 4))            code = 6;
        else begin
            code = 0;
            pa = dp_frame(s, i / 4) + i % 4;
        end
    endtask

    // memory model: latency 0 or 2 extra cycles, one-cycle ack
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 1024; a++) mem[a] <= init_word(a);
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= (mem_addr[0] ? 0 : 2)) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr];
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic xlate(input int s, input int i, input int o,
                         output int code, output int pa, output int rd, output int wr);
        int r0, w0;
        bit seen;
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        while (!ready) @(negedge clk);
        seg = SEG_W'(s); idx = IDX_W'(i); op = 2'(o); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        code = -1;
        pa = -1;
        for (int k = 0; k < 300 && !seen; k++) begin
            if (done || fault) begin
                seen = 1'b1;
                if (done && fault) chk("R10 both pulses", 1, 0);
                code = fault ? int'(fault_code) : 0;
                pa = done ? int'(paddr) : 0;
            end else begin
                @(negedge clk);
            end
        end
        rd = rd_cnt - r0;
        wr = wr_cnt - w0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, p, rd, wr, ec, ep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R10
        chk("R10 ready after reset", int'(ready), 1);
        chk("R10 no pulse after reset", int'(done || fault), 0);
        chk("R10 no request after reset", int'(mem_req), 0);

        dbr_len = 4'd13;
        // R2 R6 R7: first walk from memory, write op on segment 1
        xlate(1, 5, 1, c, p, rd, wr);
        chk("R6 code", c, 0);
        chk("R6 paddr", p, dp_frame(1, 1) + 1);
        chk("R2 reads", rd, 3);
        chk("R7 writebacks", wr, 2);
        chk("R7 dir PTW used", int'(mem[0][WD-2]), 1);
        chk("R7 data PTW used", int'(mem[s_pt(1) + 1][WD-2]), 1);
        // R8: cached repeat
        xlate(1, 5, 1, c, p, rd, wr);
        chk("R8 cached paddr", p, dp_frame(1, 1) + 1);
        chk("R8 cached reads", rd + wr, 0);
        // R8 + R5: checks still applied on cached descriptor (read denied)
        xlate(1, 5, 0, c, p, rd, wr);
        chk("R5 cached deny code", c, 5);
        chk("R8 cached deny traffic", rd + wr, 0);
        // R9: flush forces refetch
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        xlate(1, 5, 1, c, p, rd, wr);
        chk("R9 reads after flush", rd, 3);
        chk("R9 paddr after flush", p, dp_frame(1, 1) + 1);
        // R1: bound fault with no traffic
        dbr_len = 4'd3;
        xlate(4, 0, 0, c, p, rd, wr);
        chk("R1 code", c, 1);
        chk("R1 traffic", rd + wr, 0);

        // exhaustive sweep
        dbr_len = 4'd13;
        for (int s = 0; s < 16; s++) begin
            for (int i = 0; i < 16; i++) begin
                for (int o = 0; o < 4; o++) begin
                    xlate(s, i, o, c, p, rd, wr);
                    expect_of(s, i, o, 13, ec, ep);
                    case (ec)
                        1: chk("R1 sweep code", c, ec);
                        2: chk("R2 sweep code", c, ec);
                        3: chk("R3 sweep code", c, ec);
                        4: chk("R4 sweep code", c, ec);
                        5: chk("R5 sweep code", c, ec);
                        default: begin
                            chk("R6 sweep code", c, ec);
                            if (ec == 0) chk("R6 sweep paddr", p, ep);
                        end
                    endcase
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule